// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is an I2C target that answers at one 7-bit address. It runs on a local system clock that is much faster than the bus clock. SCL and SDA are passed through synchronizers. The block drives the bus only through drive-low enables.

The expected transaction has two phases. A write transfer carries a command byte. A repeated start followed by a read transfer then fetches one or more response bytes. The local logic sees every written byte on a valid/ready handshake and learns which byte was the command.

The local logic supplies response bytes when asked. While it works, the target holds SCL low. It does so after acknowledging a read address and before every further read byte. It also holds SCL low after a written byte that the local side has not yet taken. This replaces fixed delays on the bus master: the master cannot read an undriven, floating bus.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, scl_oe, sda_oe, rx_valid and tx_req are all low.
- R2: An address byte whose upper seven bits equal DEV_ADDR and whose LSB is 0 (write) is acknowledged. The target drives SDA low during the ninth clock. It does not hold SCL low for that address.
- R3: An address byte for another address gets no acknowledge. After it, the target drives neither line and raises no rx_valid until the next start or stop.
- R4: Each written byte, sent MSB first, is presented on rx_data with rx_valid until rx_ready is high. rx_is_cmd is 1 for the first byte after a write address and 0 for later bytes. cmd_o takes the command byte when it is accepted.
- R5: A written byte not yet accepted by the end of its eighth clock makes the target hold SCL low until rx_ready. It then acknowledges the byte with SDA low in the ninth clock.
- R6: After acknowledging an address with LSB 1 (read), the target holds SCL low and raises tx_req until tx_valid. It then shifts tx_data out MSB first. The master therefore reads the supplied byte and not the floating value 0xFF.
- R7: A master ACK (SDA low in the ninth clock) after a read byte starts another stretched request for the next byte. A master NACK releases both lines, and tx_req stays low until the next start.
- R8: A repeated start in any state returns the target to address reception and keeps cmd_o. A following read phase therefore answers the stored command.
- R9: A stop returns the target to idle with both lines released.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_data | output | 8 | Last written byte |
| rx_is_cmd | output | 1 | rx_data is the command byte |
| rx_valid | output | 1 | rx_data waits for acceptance |
| rx_ready | input | 1 | Local side accepts rx_data |
| cmd_o | output | 8 | Stored command byte |
| tx_req | output | 1 | Target needs the next response byte |
| tx_data | input | 8 | Response byte |
| tx_valid | input | 1 | tx_data is valid; loaded while tx_req is high |

## Verification
The bench makes the local side answer late, by up to a few hundred system clocks, on both the write and the read side. It checks two things in that case. First, every bit the master reads is the supplied byte. Second, the acknowledge slot shows a measurable stretch. A target that released SCL early would let the master read 0xFF or miss the ACK.

A write address must show zero stretch. A foreign address must leave the lines untouched. After a NACK the bench checks that no further byte is requested. A target that forgot the command across the repeated start would return bytes for the wrong command. A bus monitor also flags any SDA change by the target while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_HOLD, ST_WR_REL,
    ST_WR_ACK, ST_RD_LOAD, ST_RD_REL, ST_RD_BYTE, ST_RD_ACK, ST_WAIT
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h42,
  parameter bit         STRETCH_WR = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_is_cmd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] cmd_o,
  output logic       tx_req,
  input  logic [7:0] tx_data,
  input  logic       tx_valid
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  tgt_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d, rxd_q, rxd_d, cmd_q, cmd_d;
  logic sda_q, sda_d, scl_q, scl_d, rxv_q, rxv_d, rxc_q, rxc_d;
  logic first_q, first_d, rd_q, rd_d, mack_q, mack_d;
  logic accept, take_ok;

  assign accept  = rxv_q & rx_ready;
  assign take_ok = ~rxv_q | rx_ready;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; rxd_d = rxd_q; cmd_d = cmd_q;
    sda_d = sda_q; scl_d = scl_q; rxv_d = rxv_q; rxc_d = rxc_q;
    first_d = first_q; rd_d = rd_q; mack_d = mack_q;
    if (accept) begin
      rxv_d = 1'b0;
      if (rxc_q) cmd_d = rxd_q;
    end
    if (stop_det) begin
      st_d = ST_IDLE; sda_d = 1'b0; scl_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; cnt_d = '0; sda_d = 1'b0; scl_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (sh_q[7:1] == DEV_ADDR) begin
              sda_d = 1'b1;
              rd_d  = sh_q[0];
              if (!sh_q[0]) first_d = 1'b1;
              st_d  = ST_ADDR_ACK;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          sda_d = 1'b0;
          cnt_d = '0;
          if (rd_q) begin
            st_d = ST_RD_LOAD; scl_d = 1'b1;
          end else begin
            st_d = ST_WR_BYTE;
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST && take_ok) begin
              rxv_d = 1'b1; rxd_d = {sh_q[6:0], sda_s};
              rxc_d = first_q; first_d = 1'b0;
            end
          end else if (scl_fall && cnt_q == FULL) begin
            if (take_ok) begin
              sda_d = 1'b1; st_d = ST_WR_ACK;
            end else if (STRETCH_WR) begin
              scl_d = 1'b1; st_d = ST_WR_HOLD;
            end else begin
              rxv_d = 1'b0; st_d = ST_WAIT;
            end
          end
        end
        ST_WR_HOLD: if (accept) begin
          sda_d = 1'b1; st_d = ST_WR_REL;
        end
        ST_WR_REL: begin
          scl_d = 1'b0; st_d = ST_WR_ACK;
        end
        ST_WR_ACK: if (scl_fall) begin
          sda_d = 1'b0; cnt_d = '0; st_d = ST_WR_BYTE;
        end
        ST_RD_LOAD: if (tx_valid) begin
          sh_d = tx_data; sda_d = ~tx_data[7]; cnt_d = '0; st_d = ST_RD_REL;
        end
        ST_RD_REL: begin
          scl_d = 1'b0; st_d = ST_RD_BYTE;
        end
        ST_RD_BYTE: if (scl_fall) begin
          if (cnt_q == LAST) begin
            sda_d = 1'b0; st_d = ST_RD_ACK;
          end else begin
            sh_d  = {sh_q[6:0], 1'b0};
            sda_d = ~sh_q[6];
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_d = ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_RD_LOAD; scl_d = 1'b1;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; rxd_q <= '0; cmd_q <= '0;
      sda_q <= 1'b0; scl_q <= 1'b0; rxv_q <= 1'b0; rxc_q <= 1'b0;
      first_q <= 1'b0; rd_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; rxd_q <= rxd_d; cmd_q <= cmd_d;
      sda_q <= sda_d; scl_q <= scl_d; rxv_q <= rxv_d; rxc_q <= rxc_d;
      first_q <= first_d; rd_q <= rd_d; mack_q <= mack_d;
    end
  end

  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;
  assign rx_data   = rxd_q;
  assign rx_is_cmd = rxc_q;
  assign rx_valid  = rxv_q;
  assign cmd_o     = cmd_q;
  assign tx_req    = (st_q == ST_RD_LOAD);

  // R10
  sda_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_q != $past(sda_q)) |-> !$past(scl_s));
  // R6
  req_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> scl_oe);
  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (STRETCH_WR && rxv_q && !rx_ready) |=> (rxv_q && $stable(rxd_q)));
  // R2
  wr_nostretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR_BYTE) |-> !scl_q);
  // R7
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (!sda_q && !scl_q));
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h42,
  parameter bit         STRETCH_WR  = 1'b1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_is_cmd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] cmd_o,
  output logic       tx_req,
  input  logic [7:0] tx_data,
  input  logic       tx_valid
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_core #(.DEV_ADDR(DEV_ADDR), .STRETCH_WR(STRETCH_WR)) u_core (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_is_cmd(rx_is_cmd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .cmd_o(cmd_o), .tx_req(tx_req),
    .tx_data(tx_data), .tx_valid(tx_valid)
  );
endmodule

// File: tb/sim_i2c_stretch_target.sv
`timescale 1ns/1ps
module sim_i2c_stretch_target;
  localparam int Q = 20;
  localparam logic [7:0] AW = 8'h84, AR = 8'h85;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, rx_is_cmd, rx_valid, tx_req;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] rx_data, cmd_o, tx_data = 8'h00;
  wire bus_scl = !(m_scl_low || scl_oe);
  wire bus_sda = !(m_sda_low || sda_oe);

  int errors = 0, checks = 0, cyc = 0;
  int rx_delay = 0, tx_delay = 0;
  int rx_cnt = 0, tx_cnt = 0, drv_cnt = 0, viol = 0;
  logic [7:0] rx_log [0:63];
  logic       rxc_log [0:63];
  logic prev_sda_oe = 1'b0, prev_scl = 1'b1;

  always #5 clk = ~clk;

  i2c_stretch_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data), .rx_is_cmd(rx_is_cmd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .cmd_o(cmd_o), .tx_req(tx_req),
    .tx_data(tx_data), .tx_valid(tx_valid)
  );

  function automatic logic [7:0] resp(input logic [7:0] c, input int i);
    return c * 8'd7 + 8'h11 + i[7:0] * 8'd29;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // bus monitor: R10 and drive activity
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe != prev_sda_oe && prev_scl && bus_scl) viol++;
      if (sda_oe || scl_oe) drv_cnt++;
    end
    prev_sda_oe = sda_oe;
    prev_scl    = bus_scl;
  end

  // local receive side
  initial forever begin
    @(negedge clk);
    if (rx_valid) begin
      repeat (rx_delay) @(negedge clk);
      rx_log[rx_cnt[5:0]]  = rx_data;
      rxc_log[rx_cnt[5:0]] = rx_is_cmd;
      rx_cnt++;
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  end

  // local transmit side
  initial forever begin
    @(negedge clk);
    if (tx_req) begin
      repeat (tx_delay) @(negedge clk);
      tx_data  = resp(cmd_o, tx_cnt);
      tx_valid = 1'b1;
      tx_cnt++;
      @(negedge clk);
      tx_valid = 1'b0;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rel_scl(output int st);
    m_scl_low = 1'b0; st = 0;
    @(negedge clk);
    while (!bus_scl) begin st++; @(negedge clk); end
  endtask

  task automatic m_start;
    m_sda_low = 1'b1; wt(2*Q); m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic m_rstart;
    int s;
    m_sda_low = 1'b0; wt(Q); rel_scl(s); wt(Q);
    m_sda_low = 1'b1; wt(Q); m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic m_stop;
    int s;
    m_sda_low = 1'b1; wt(Q); rel_scl(s); wt(Q); m_sda_low = 1'b0; wt(2*Q);
  endtask

  task automatic m_wbit(input bit b, output int st);
    m_sda_low = !b; wt(Q); rel_scl(st); wt(2*Q); m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic m_rbit(output bit b, output int st);
    m_sda_low = 1'b0; wt(Q); rel_scl(st); wt(Q); b = bus_sda; wt(Q);
    m_scl_low = 1'b1; wt(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output bit ack, output int ack_st);
    bit b; int s;
    for (int i = 7; i >= 0; i--) m_wbit(d[i], s);
    m_rbit(b, ack_st);
    ack = !b;
  endtask

  task automatic m_rbyte(input bit ack, output logic [7:0] d, output int st0);
    bit b; int s;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b, s);
      d[i] = b;
      if (i == 7) st0 = s;
    end
    m_wbit(!ack, s);
  endtask

  // full command + read transaction with checks
  task automatic cmd_read(input logic [7:0] c, input int nb, input int ndata);
    bit ack; int ast, st0, base, r0; logic [7:0] d;
    r0 = rx_cnt;
    m_start;
    m_wbyte(AW, ack, ast);
    chk(ack, "R2 write address ack", ack, 1);
    m_wbyte(c, ack, ast);
    chk(ack, "R4 command ack", ack, 1);
    for (int j = 0; j < ndata; j++) begin
      m_wbyte(c ^ j[7:0], ack, ast);
      chk(ack, "R5 data ack", ack, 1);
      if (rx_delay > 150) chk(ast > 0, "R5 stretch after data", ast, 1);
    end
    wt(4);
    chk(rx_cnt == r0 + 1 + ndata, "R4 byte count", rx_cnt - r0, 1 + ndata);
    chk(rx_log[r0[5:0]] == c && rxc_log[r0[5:0]], "R4 command byte",
        {rxc_log[r0[5:0]], rx_log[r0[5:0]]}, {1'b1, c});
    for (int j = 0; j < ndata; j++)
      chk(rx_log[r0+1+j] == (c ^ j[7:0]) && !rxc_log[r0+1+j], "R4 data byte",
          rx_log[r0+1+j], c ^ j[7:0]);
    chk(cmd_o == c, "R4 cmd_o", cmd_o, c);
    m_rstart;
    chk(cmd_o == c, "R8 cmd kept over repeated start", cmd_o, c);
    base = tx_cnt;
    m_wbyte(AR, ack, ast);
    chk(ack, "R6 read address ack", ack, 1);
    for (int k = 0; k < nb; k++) begin
      m_rbyte(k != nb - 1, d, st0);
      chk(d == resp(c, base + k), "R6 read byte", d, resp(c, base + k));
      if (tx_delay > 100) chk(st0 > 0, "R7 stretch before read byte", st0, 1);
    end
    m_stop;
  endtask

  initial begin
    bit ack; int ast, st0, dc, seed, base; logic [7:0] d, c;
    seed = $urandom(32'd20240917);
    wt(5);
    chk(!scl_oe && !sda_oe && !rx_valid && !tx_req, "R1 reset state",
        {scl_oe, sda_oe, rx_valid, tx_req}, 0);
    rst_n = 1'b1;
    wt(10);
    chk(!scl_oe && !sda_oe && !rx_valid && !tx_req, "R1 after release",
        {scl_oe, sda_oe, rx_valid, tx_req}, 0);

    // write address only: ack, no stretch (R2)
    rx_delay = 0;
    m_start;
    m_wbyte(AW, ack, ast);
    chk(ack, "R2 ack on write address", ack, 1);
    chk(ast == 0, "R2 no stretch on write address", ast, 0);
    m_stop;
    chk(!scl_oe && !sda_oe, "R9 idle after stop", {scl_oe, sda_oe}, 0);

    // foreign address (R3)
    dc = drv_cnt; base = rx_cnt;
    m_start;
    m_wbyte(8'h90, ack, ast);
    chk(!ack, "R3 no ack for other address", ack, 0);
    m_wbyte(8'h55, ack, ast);
    chk(!ack && rx_cnt == base, "R3 byte ignored", rx_cnt - base, 0);
    chk(drv_cnt == dc, "R3 lines untouched", drv_cnt - dc, 0);
    m_stop;

    // directed: slow local side on both sides (R5, R6, R7)
    rx_delay = 300; tx_delay = 400;
    cmd_read(8'h3C, 3, 2);
    chk(resp(8'h3C, 0) != 8'hFF, "R6 expected byte differs from float", 0, 1);

    // NACK ends the read (R7)
    tx_delay = 200;
    m_start;
    m_wbyte(AR, ack, ast);
    m_rbyte(1'b0, d, st0);
    dc = drv_cnt; base = tx_cnt;
    wt(400);
    chk(!tx_req && tx_cnt == base, "R7 no request after NACK", tx_cnt - base, 0);
    chk(drv_cnt == dc, "R7 lines released after NACK", drv_cnt - dc, 0);
    m_stop;

    // read without a new command uses stored command (R8)
    m_start;
    m_wbyte(AW, ack, ast);
    m_rstart;
    base = tx_cnt;
    m_wbyte(AR, ack, ast);
    m_rbyte(1'b0, d, st0);
    chk(d == resp(8'h3C, base), "R8 stored command answered", d, resp(8'h3C, base));
    chk(st0 > 0, "R6 stretch before first read bit", st0, 1);
    m_stop;

    // random transactions
    for (int n = 0; n < 6; n++) begin
      c = $urandom;
      rx_delay = $urandom % 250;
      tx_delay = $urandom % 250;
      cmd_read(c, 1 + $urandom % 3, $urandom % 3);
    end

    wt(20);
    chk(viol == 0, "R10 SDA changed with SCL high", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule